// File: doc/BRIEF.md
# Byte-Serial Substitution, Key-Mix and Row-Rotate Engine

This block carries out three steps of a byte-oriented block-cipher round in one pass over a 16-byte state. The state is a grid of 4 rows by 4 columns. Each byte is handled in turn. Its value indexes a 256-entry substitution table, and the table output is XORed with the round-key byte at the same position. The result is then stored into an output buffer at a position where its row has been rotated. The rotation is done only by the choice of write address: there is no separate shifting stage.

A pass begins with a one-cycle start pulse while the engine is idle. At that edge the engine captures the input block. It then handles one byte per cycle in ascending source index. The time taken is the same whatever the data. A one-cycle done pulse marks the point where the complete result is on the output. The substitution table is loaded at run time through a byte-wide write port, so the same engine can serve any table. Column mixing, key expansion and the inverse round are not part of this block.

Top module: `sks_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` and `done` are 0 and `blk_out` is all zeros.
- R2: A `start` pulse sampled while `busy` is 0 captures `blk_in` and sets `busy` on that edge. `done` goes high, and `busy` goes low, on the 17th rising edge after the edge that sampled `start`.
- R3: The 17-edge latency of R2 is the same for every block value, key value and table content.
- R4: Byte i of a block occupies bits [8i+7:8i], and i = column*4 + row. Source byte s produces the value T[blk_in byte s] XOR rkey byte s, where T is the table.
- R5: The value from source (column c, row r) is written to output byte ((c - r) mod 4)*4 + r. Each row r is therefore rotated left by r columns.
- R6: `done` is high for exactly one cycle per pass.
- R7: A write with `tbl_we`=1 while `busy` is 0 sets T[`tbl_addr`] = `tbl_wdata`. A write while `busy` is 1 is ignored, both by the pass in progress and by later passes.
- R8: A `start` pulse while `busy` is 1 is ignored. The running pass ends on schedule with its own result, and no second pass follows.
- R9: While idle, `blk_out` holds the result of the last pass, whatever happens on `blk_in` and `rkey`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a pass |
| blk_in | input | 128 | State block, captured when start is accepted |
| rkey | input | 128 | Round key, held stable from start until done |
| tbl_we | input | 1 | Substitution table write strobe |
| tbl_addr | input | 8 | Table entry to write |
| tbl_wdata | input | 8 | Value to write to the table entry |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse: result complete on blk_out |
| blk_out | output | 128 | Substituted, key-mixed and row-rotated state |

## Verification
The hardest cases to reach from the ports are events that land in the middle of a pass. One is a table write aimed at an entry the pass has not yet looked up. The other is a second start pulse arriving while the engine is busy. The bench counts cycles from the accepted start, so it places each injection at a known byte of the pass. The table write targets the entry that the final source byte will use. The bench then compares the finished block and the done timing against a model that never saw the injected event. The row rotation is checked separately: an identity table and a zero key make every output byte equal to its own source index.

// File: rtl/sks_pkg.sv
package sks_pkg;

  // Destination index of source byte idx in a rows x cols grid stored
  // column-major; row r is rotated left by r columns.
  function automatic int scatter_dest(input int idx, input int rows, input int cols);
    int c;
    int r;
    int nc;
    c  = idx / rows;
    r  = idx % rows;
    nc = (((c - (r % cols)) % cols) + cols) % cols;
    return nc * rows + r;
  endfunction

endpackage

// File: rtl/sks_sbox_ram.sv
module sks_sbox_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sks_sequencer.sv
module sks_sequencer #(
  parameter int NB   = 16,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            load,
  output logic            busy,
  output logic            done,
  output logic            rd_en,
  output logic [IDXW-1:0] rd_idx,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NB - 1);

  logic            busy_q, rd_act_q, wr_vld_q, done_q;
  logic [IDXW-1:0] rd_cnt_q, wr_idx_q;

  assign load = start && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      rd_act_q <= 1'b0;
      wr_vld_q <= 1'b0;
      done_q   <= 1'b0;
      rd_cnt_q <= '0;
      wr_idx_q <= '0;
    end else begin
      done_q   <= 1'b0;
      wr_vld_q <= rd_act_q;
      wr_idx_q <= rd_cnt_q;
      if (load) begin
        busy_q   <= 1'b1;
        rd_act_q <= 1'b1;
        rd_cnt_q <= '0;
      end else if (rd_act_q) begin
        if (rd_cnt_q == LAST) begin
          rd_act_q <= 1'b0;
          rd_cnt_q <= '0;
        end else begin
          rd_cnt_q <= rd_cnt_q + 1'b1;
        end
      end
      if (wr_vld_q && (wr_idx_q == LAST)) begin
        done_q <= 1'b1;
        busy_q <= 1'b0;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign rd_en  = rd_act_q;
  assign rd_idx = rd_cnt_q;
  assign wr_en  = wr_vld_q;
  assign wr_idx = wr_idx_q;
endmodule

// File: rtl/sks_scatter_buf.sv
module sks_scatter_buf #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [ROWS*COLS*DW-1:0]     load_blk,
  input  logic [$clog2(ROWS*COLS)-1:0] rd_idx,
  output logic [DW-1:0]               rd_byte,
  input  logic                        wr_en,
  input  logic [$clog2(ROWS*COLS)-1:0] wr_idx,
  input  logic [DW-1:0]               wr_byte,
  output logic [ROWS*COLS*DW-1:0]     out_blk
);
  localparam int NB   = ROWS * COLS;
  localparam int IDXW = $clog2(NB);

  logic [DW-1:0]   src_q    [NB];
  logic [DW-1:0]   dst_q    [NB];
  logic [IDXW-1:0] dest_map [NB];

  // dispersion lives only in this constant write-address map
  for (genvar i = 0; i < NB; i++) begin : g_map
    localparam int DST = sks_pkg::scatter_dest(i, ROWS, COLS);
    assign dest_map[i] = IDXW'(DST);
    assign out_blk[i*DW +: DW] = dst_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) src_q[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NB; i++) src_q[i] <= load_blk[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) dst_q[i] <= '0;
    end else if (wr_en) begin
      dst_q[dest_map[wr_idx]] <= wr_byte;
    end
  end

  assign rd_byte = src_q[rd_idx];
endmodule

// File: rtl/sks_engine.sv
module sks_engine #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ROWS*COLS*DW-1:0] blk_in,
  input  logic [ROWS*COLS*DW-1:0] rkey,
  input  logic                    tbl_we,
  input  logic [DW-1:0]           tbl_addr,
  input  logic [DW-1:0]           tbl_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [ROWS*COLS*DW-1:0] blk_out
);
  localparam int NB   = ROWS * COLS;
  localparam int IDXW = $clog2(NB);

  logic            load, rd_en, wr_en;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic [DW-1:0]   src_byte, sub_byte, mix_byte;
  logic [DW-1:0]   key_b [NB];

  for (genvar i = 0; i < NB; i++) begin : g_key
    assign key_b[i] = rkey[i*DW +: DW];
  end

  sks_sequencer #(.NB(NB), .IDXW(IDXW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .load   (load),
    .busy   (busy),
    .done   (done),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .wr_en  (wr_en),
    .wr_idx (wr_idx)
  );

  sks_sbox_ram #(.AW(DW), .DW(DW)) u_tbl (
    .clk   (clk),
    .we    (tbl_we && !busy),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .re    (rd_en),
    .raddr (src_byte),
    .rdata (sub_byte)
  );

  assign mix_byte = sub_byte ^ key_b[wr_idx];

  sks_scatter_buf #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_blk (blk_in),
    .rd_idx   (rd_idx),
    .rd_byte  (src_byte),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_byte  (mix_byte),
    .out_blk  (blk_out)
  );
endmodule

// File: rtl/sks_engine_chk.sv
module sks_engine_chk #(
  parameter int NB   = 16,
  parameter int BLKW = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [BLKW-1:0] blk_out
);
  localparam int CW = $clog2(NB + 2) + 1;

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst)                 cyc_q <= '0;
    else if (start && !busy) cyc_q <= '0;
    else if (busy)           cyc_q <= cyc_q + 1'b1;
  end

  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);                                   // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc_q == CW'(NB + 1)));                             // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                              // R2
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);                                        // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                              // R6
  AST_RESTART_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && (cyc_q < CW'(NB))) |=> busy);               // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(blk_out));                // R9
endmodule

bind sks_engine sks_engine_chk #(.NB(NB), .BLKW(NB*DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .blk_out (blk_out)
);

// File: tb/tb_sks_engine.sv
module tb_sks_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] blk_in = '0;
  logic [127:0] rkey = '0;
  logic         tbl_we = 1'b0;
  logic [7:0]   tbl_addr = '0;
  logic [7:0]   tbl_wdata = '0;
  logic         busy, done;
  logic [127:0] blk_out;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  logic [7:0] tbl_m [256];

  localparam int NV = 5;
  localparam logic [127:0] VBLK [NV] = '{
    128'h0,
    {16{8'hFF}},
    128'h00112233_44556677_8899AABB_CCDDEEFF,
    128'h3C5A7E01_9BD2F4E6_10203040_A5C3E781,
    128'hDEADBEEF_01234567_89ABCDEF_F0E1D2C3
  };
  localparam logic [127:0] VKEY [NV] = '{
    128'h0,
    128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
    {16{8'hFF}},
    128'h2B7E1516_28AED2A6_ABF71588_09CF4F3C,
    128'h0
  };

  sks_engine dut (
    .clk(clk), .rst(rst), .start(start), .blk_in(blk_in), .rkey(rkey),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .busy(busy), .done(done), .blk_out(blk_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic [127:0] model(input logic [127:0] b, input logic [127:0] k);
    logic [127:0] o;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        int s;
        int d;
        s = c * 4 + r;
        d = ((c - r + 4) % 4) * 4 + r;
        o[d*8 +: 8] = tbl_m[b[s*8 +: 8]] ^ k[s*8 +: 8];
      end
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tbl_write(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_table(input bit ident);
    for (int a = 0; a < 256; a++) begin
      logic [7:0] v;
      v = ident ? 8'(a) : 8'(a * 7 + 8'h63);
      tbl_m[a] = v;
      tbl_write(8'(a), v);
    end
  endtask

  // start a pass; lat counts rising edges after the start edge until done
  task automatic run_pass(input logic [127:0] b, input logic [127:0] k, output int lat);
    @(negedge clk);
    blk_in = b; rkey = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [127:0] exp, held;
    int dones;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", 128'(busy), 128'h0);
    check(done == 1'b0, "R1 done in reset", 128'(done), 128'h0);
    check(blk_out == '0, "R1 blk_out in reset", blk_out, 128'h0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && blk_out == '0, "R1 after reset",
          {blk_out[125:0], busy, done}, 128'h0);

    // vector table: R2, R3, R4, R6
    load_table(1'b0);
    for (int v = 0; v < NV; v++) begin
      exp = model(VBLK[v], VKEY[v]);
      run_pass(VBLK[v], VKEY[v], lat);
      check(lat == 17, "R2 R3 done latency", 128'(lat), 128'd17);
      check(blk_out == exp, "R4 result", blk_out, exp);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R6 done single cycle",
            {126'h0, done, busy}, 128'h0);
    end

    // R5: identity table, zero key, byte value = source index
    load_table(1'b1);
    held = '0;
    for (int i = 0; i < 16; i++) held[i*8 +: 8] = 8'(i);
    run_pass(held, 128'h0, lat);
    check(blk_out[15:8] == 8'd5, "R5 row1 col0 from col1", 128'(blk_out[15:8]), 128'd5);
    check(blk_out[31:24] == 8'd15, "R5 row3 col0 from col3", 128'(blk_out[31:24]), 128'd15);
    check(blk_out[39:32] == 8'd4, "R5 row0 col1 unmoved", 128'(blk_out[39:32]), 128'd4);
    check(blk_out[127:120] == 8'd11, "R5 row3 col3 from col2", 128'(blk_out[127:120]), 128'd11);

    // R7: table write during a pass targets the entry byte 15 uses (0x0F)
    @(negedge clk);
    blk_in = held; rkey = 128'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      tbl_we = (lat == 3); tbl_addr = 8'h0F; tbl_wdata = 8'hEE;
      @(negedge clk);
      lat++;
    end
    tbl_we = 1'b0;
    exp = model(held, 128'h0);
    check(blk_out == exp, "R7 busy write ignored in pass", blk_out, exp);
    run_pass(held, 128'h0, lat);
    check(blk_out == exp, "R7 busy write ignored later", blk_out, exp);
    tbl_write(8'h0F, 8'hEE);
    tbl_m[8'h0F] = 8'hEE;
    run_pass(held, 128'h0, lat);
    check(blk_out[31:24] == 8'hEE, "R7 idle write takes effect", 128'(blk_out[31:24]), 128'hEE);

    // R8: second start while busy
    exp = model(VBLK[3], VKEY[3]);
    @(negedge clk);
    blk_in = VBLK[3]; rkey = VKEY[3]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      start = (lat == 5);
      if (lat == 5) blk_in = VBLK[4];
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == 17, "R8 latency with extra start", 128'(lat), 128'd17);
    check(blk_out == exp, "R8 result of first pass", blk_out, exp);
    dones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || busy) dones++;
    end
    check(dones == 0, "R8 no second pass", 128'(dones), 128'd0);

    // R9: output holds while idle as inputs change
    held = blk_out;
    blk_in = ~blk_in; rkey = 128'h5555_AAAA_5555_AAAA_5555_AAAA_5555_AAAA;
    repeat (10) @(negedge clk);
    check(blk_out == held, "R9 hold while idle", blk_out, held);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule